// File: doc/BRIEF.md
# CRM Switching Cycle Sequencer

This block decides when the power switch of a critical-conduction-mode boost stage is on. Turn-on is not clocked. A cycle begins when the inductor-current comparator falls, meaning the inductor current has returned to zero. The falling edge passes through a two-flop synchronizer and then a short fixed turn-on delay before the gate rises. The gate then stays on while an internal ramp counter climbs. The ramp starts at a code that stands for 1.0 V and advances one step every `TICK_DIV` clocks. The gate turns off when the ramp reaches the error-amplifier level `comp_code`, which is expressed in the same units.

Several guards surround this loop:

- **Minimum period.** Comparator edges that arrive too soon after the previous turn-on are discarded, so that ringing cannot drive the stage into continuous conduction.
- **Restart timer.** If the gate has been off for too long with no usable edge, a turn-on is forced.
- **Over-current.** An over-current flag cuts the on-time short.
- **COMP range.** COMP codes below the 1.0 V point stop switching. Codes above the 6.5 V point are clamped, which caps the on-time.
- **Supervisor inhibits.** Four inhibit inputs from the supervisor each stop the gate and cancel a turn-on that is waiting.

All pins are plain control and status levels or single-cycle pulses. There is no streaming interface and no handshake.

Top module: `crm_gate_sequencer`

## Requirements
- R1: A falling edge on `zcd_cmp`, accepted while the gate is off, raises `gate` TURNON_DLY+2 clock edges after the first edge at which the new low level is sampled. This comes from two synchronizer flops and TURNON_DLY cycles of turn-on delay.
- R2: Each on-time lasts (C-COMP_MIN)*TICK_DIV+1 clock cycles, where C is `comp_code`. The ramp starts at COMP_MIN when the gate rises and gains one code per TICK_DIV clocks.
- R3: A `comp_code` above COMP_MAX behaves exactly as COMP_MAX, so no on-time exceeds (COMP_MAX-COMP_MIN)*TICK_DIV+1 cycles.
- R4: While `comp_code` is below COMP_MIN, the gate stays low. Comparator edges have no effect and the restart timer does not run.
- R5: `ocp_flag` sampled high while the gate is on drives `gate` low at the next clock edge. `ocp_end` pulses high for one cycle in the same cycle that the gate goes low.
- R6: A comparator falling edge detected fewer than BLANK_CYC cycles after the last gate rise is discarded, and `zcd_drop` pulses for one cycle. A later edge is still accepted.
- R7: After RESTART_CYC consecutive clock cycles with the gate off, switching enabled and no accepted edge, the gate is forced on without the turn-on delay. `restart_fire` pulses high in the first on cycle.
- R8: Any set bit of `inhibit` (bit 0 lockout, bit 1 over-voltage, bit 2 disable, bit 3 thermal) drives `gate` low at the next clock edge. It cancels a turn-on that is in its delay phase, and it holds the restart timer cleared.
- R9: During and right after reset, `gate`, `zcd_drop`, `restart_fire` and `ocp_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zcd_cmp | input | 1 | Zero-current comparator output (asynchronous) |
| ocp_flag | input | 1 | Over-current comparator flag |
| comp_code | input | COMP_W | Error-amplifier level in ramp units |
| inhibit | input | 4 | Supervisor stops: lockout, over-voltage, disable, thermal |
| gate | output | 1 | Power-switch gate command |
| zcd_drop | output | 1 | Pulse: comparator edge discarded inside the blanking window |
| restart_fire | output | 1 | Pulse: turn-on forced by the restart timer |
| ocp_end | output | 1 | Pulse: on-time ended by over-current |

## Verification
The bench builds the block with the following parameters:

| Parameter | Bench value |
|---|---|
| TICK_DIV | 2 |
| BLANK_CYC | 30 |
| RESTART_CYC | 400 |
| TURNON_DLY | 3 |

COMP_MIN and COMP_MAX keep their defaults of 20 and 130. With these values a full-scale on-time is 221 cycles, so both the clamped and the unclamped ramp endpoints can be measured exactly. They also let a forced restart and a long inhibited wait fit in a few hundred cycles. The short turn-on delay keeps the edge-to-gate latency small enough to time on every cycle, while leaving a real delay phase in which an inhibit can cancel a turn-on that is still waiting.

// File: rtl/crm_seq_pkg.sv
package crm_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_ON   = 2'd2
  } crm_state_e;

  localparam int INH_LOCKOUT = 0;
  localparam int INH_OVERV   = 1;
  localparam int INH_DISABLE = 2;
  localparam int INH_THERMAL = 3;
  localparam int INH_N       = 4;
endpackage

// File: rtl/crm_zcd_edge.sv
module crm_zcd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= cmp_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall = prev_q & ~sync_q;
endmodule

// File: rtl/crm_ramp.sv
module crm_ramp #(
  parameter int COMP_W   = 8,
  parameter int COMP_MIN = 20,
  parameter int COMP_MAX = 130,
  parameter int TICK_DIV = 377
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [COMP_W-1:0] comp_code,
  output logic              done
);
  localparam logic [COMP_W-1:0] MIN_C = COMP_W'(COMP_MIN);
  localparam logic [COMP_W-1:0] MAX_C = COMP_W'(COMP_MAX);

  logic [COMP_W-1:0] ramp_q;
  logic [COMP_W-1:0] level;
  logic              step;

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign step = run;
    end else begin : g_prescale
      localparam int TW = $clog2(TICK_DIV);
      logic [TW-1:0] tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            tick_q <= '0;
        else if (start || !run)                tick_q <= '0;
        else if (tick_q == TW'(TICK_DIV - 1))  tick_q <= '0;
        else                                   tick_q <= tick_q + 1'b1;
      end
      assign step = run && !start && (tick_q == TW'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ramp_q <= MIN_C;
    else if (start)                   ramp_q <= MIN_C;
    else if (step && ramp_q != MAX_C) ramp_q <= ramp_q + 1'b1;
  end

  assign level = (comp_code > MAX_C) ? MAX_C : comp_code;
  assign done  = (ramp_q >= level);
endmodule

// File: rtl/crm_interval_timers.sv
module crm_interval_timers #(
  parameter int BLANK_CYC   = 330,
  parameter int RESTART_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_rise,
  input  logic off_run,
  output logic blank_open,
  output logic restart_due
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int OW = $clog2(RESTART_CYC);
  localparam logic [BW-1:0] BLANK_C = BW'(BLANK_CYC);
  localparam logic [OW-1:0] LAST_C  = OW'(RESTART_CYC - 1);

  logic [BW-1:0] since_q;
  logic [OW-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= BLANK_C;
    else if (gate_rise)         since_q <= '0;
    else if (since_q != BLANK_C) since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              off_q <= '0;
    else if (!off_run)       off_q <= '0;
    else if (off_q != LAST_C) off_q <= off_q + 1'b1;
  end

  assign blank_open  = (since_q == BLANK_C);
  assign restart_due = off_run && (off_q == LAST_C);
endmodule

// File: rtl/crm_gate_sequencer.sv
module crm_gate_sequencer
  import crm_seq_pkg::*;
#(
  parameter int COMP_W      = 8,
  parameter int COMP_MIN    = 20,
  parameter int COMP_MAX    = 130,
  parameter int TICK_DIV    = 377,
  parameter int BLANK_CYC   = 330,
  parameter int RESTART_CYC = 15000,
  parameter int TURNON_DLY  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zcd_cmp,
  input  logic              ocp_flag,
  input  logic [COMP_W-1:0] comp_code,
  input  logic [3:0]        inhibit,
  output logic              gate,
  output logic              zcd_drop,
  output logic              restart_fire,
  output logic              ocp_end
);
  localparam int DW = (TURNON_DLY > 1) ? $clog2(TURNON_DLY) : 1;
  localparam logic [COMP_W-1:0] MIN_C = COMP_W'(COMP_MIN);

  crm_state_e state_q, state_d;
  logic [DW-1:0] dly_q;
  logic fall, blank_open, restart_due, ramp_done;
  logic run_ok, any_inh, enter_on;
  logic drop_d, restart_d, ocp_d;

  crm_zcd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cmp_async(zcd_cmp), .fall(fall)
  );

  crm_interval_timers #(.BLANK_CYC(BLANK_CYC), .RESTART_CYC(RESTART_CYC)) u_timers (
    .clk(clk), .rst_n(rst_n), .gate_rise(enter_on),
    .off_run(state_q == ST_IDLE && run_ok),
    .blank_open(blank_open), .restart_due(restart_due)
  );

  crm_ramp #(.COMP_W(COMP_W), .COMP_MIN(COMP_MIN), .COMP_MAX(COMP_MAX),
             .TICK_DIV(TICK_DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .start(enter_on), .run(state_q == ST_ON),
    .comp_code(comp_code), .done(ramp_done)
  );

  assign any_inh = |inhibit;
  assign run_ok  = !any_inh && (comp_code >= MIN_C);

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    ocp_d     = 1'b0;
    drop_d    = fall && !blank_open;
    unique case (state_q)
      ST_IDLE: begin
        if (run_ok) begin
          if (fall && blank_open) state_d = ST_ARM;
          else if (restart_due) begin
            state_d   = ST_ON;
            restart_d = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (!run_ok)                             state_d = ST_IDLE;
        else if (dly_q == DW'(TURNON_DLY - 1))   state_d = ST_ON;
      end
      ST_ON: begin
        if (any_inh) state_d = ST_IDLE;
        else if (ocp_flag) begin
          state_d = ST_IDLE;
          ocp_d   = 1'b1;
        end else if (ramp_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign enter_on = (state_d == ST_ON) && (state_q != ST_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      dly_q        <= '0;
      zcd_drop     <= 1'b0;
      restart_fire <= 1'b0;
      ocp_end      <= 1'b0;
    end else begin
      state_q      <= state_d;
      dly_q        <= (state_q == ST_ARM) ? dly_q + 1'b1 : '0;
      zcd_drop     <= drop_d;
      restart_fire <= restart_d;
      ocp_end      <= ocp_d;
    end
  end

  assign gate = (state_q == ST_ON);
endmodule

// File: rtl/crm_gate_sequencer_chk.sv
module crm_gate_sequencer_chk #(
  parameter int COMP_W    = 8,
  parameter int COMP_MIN  = 20,
  parameter int COMP_MAX  = 130,
  parameter int TICK_DIV  = 377,
  parameter int BLANK_CYC = 330
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ocp_flag,
  input logic [COMP_W-1:0] comp_code,
  input logic [3:0]        inhibit,
  input logic              gate,
  input logic              restart_fire,
  input logic              ocp_end
);
  localparam int MAX_ON = (COMP_MAX - COMP_MIN) * TICK_DIV + 1;

  logic gate_d;
  int   gap_q;
  int   hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d <= 1'b0;
      gap_q  <= BLANK_CYC;
      hi_q   <= 0;
    end else begin
      gate_d <= gate;
      if (gate && !gate_d)     gap_q <= 1;
      else if (gap_q < BLANK_CYC) gap_q <= gap_q + 1;
      hi_q <= gate ? hi_q + 1 : 0;
    end
  end

  p_inhibit_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|inhibit) |=> !gate);

  p_ocp_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && ocp_flag && !(|inhibit)) |=> (!gate && ocp_end));

  p_comp_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && comp_code < COMP_W'(COMP_MIN)) |=> !gate);

  p_rise_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_d) |-> (gap_q >= BLANK_CYC));

  p_on_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (hi_q < MAX_ON));

  p_restart_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_fire |-> (gate && !gate_d));
endmodule

bind crm_gate_sequencer crm_gate_sequencer_chk #(
  .COMP_W(COMP_W), .COMP_MIN(COMP_MIN), .COMP_MAX(COMP_MAX),
  .TICK_DIV(TICK_DIV), .BLANK_CYC(BLANK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ocp_flag(ocp_flag), .comp_code(comp_code),
  .inhibit(inhibit), .gate(gate), .restart_fire(restart_fire), .ocp_end(ocp_end)
);

// File: tb/crm_gate_sequencer_bench.sv
module crm_gate_sequencer_bench;
  localparam int COMP_W = 8;
  localparam int CMIN = 20;
  localparam int CMAX = 130;
  localparam int TDIV = 2;
  localparam int BLANK = 30;
  localparam int RSTC = 400;
  localparam int DLY = 3;
  localparam int LAT = DLY + 3;

  typedef struct packed {
    logic [7:0] comp;
    int         cut_at;
    int         exp_on;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'd20,  0,   1}, '{8'd21, 0,   3}, '{8'd50, 0,  61},
    '{8'd130, 0, 221}, '{8'd200, 0, 221}, '{8'd255, 0, 221},
    '{8'd100, 5,   5}, '{8'd60,  1,   1}, '{8'd25, 50, 11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zcd_cmp = 1'b0;
  logic ocp_flag = 1'b0;
  logic [COMP_W-1:0] comp_code = '0;
  logic [3:0] inhibit = '0;
  logic gate, zcd_drop, restart_fire, ocp_end;
  logic drop_seen = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int lat, on_cnt;

  always #5 clk = ~clk;

  crm_gate_sequencer #(
    .COMP_W(COMP_W), .COMP_MIN(CMIN), .COMP_MAX(CMAX), .TICK_DIV(TDIV),
    .BLANK_CYC(BLANK), .RESTART_CYC(RSTC), .TURNON_DLY(DLY)
  ) u_crm_gate_sequencer (
    .clk(clk), .rst_n(rst_n), .zcd_cmp(zcd_cmp), .ocp_flag(ocp_flag),
    .comp_code(comp_code), .inhibit(inhibit), .gate(gate),
    .zcd_drop(zcd_drop), .restart_fire(restart_fire), .ocp_end(ocp_end)
  );

  always @(negedge clk) if (zcd_drop) drop_seen = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cut_kind 0: over-current; 1..4: inhibit bit cut_kind-1
  task automatic run_cycle(input logic [7:0] c, input int cut_at, input int cut_kind);
    comp_code = c;
    zcd_cmp = 1'b1;
    repeat (40) @(negedge clk);
    zcd_cmp = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!gate && lat < 60);
    on_cnt = 0;
    while (gate && on_cnt < 1000) begin
      on_cnt++;
      if (on_cnt == cut_at) begin
        if (cut_kind == 0) ocp_flag = 1'b1;
        else inhibit[cut_kind-1] = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  task automatic watch_quiet(input int n, output int rises);
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate) rises++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hits;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(!gate && !zcd_drop && !restart_fire && !ocp_end, "R9 outputs in reset",
          {gate, zcd_drop, restart_fire, ocp_end}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!gate && !zcd_drop && !restart_fire && !ocp_end, "R9 outputs after reset",
          {gate, zcd_drop, restart_fire, ocp_end}, 0);

    // table walk: R1 latency, R2/R3 ramp length, R5 over-current cut
    for (int v = 0; v < 9; v++) begin
      run_cycle(VEC[v].comp, VEC[v].cut_at, 0);
      check(lat == LAT, "R1 edge-to-gate latency", lat, LAT);
      if (VEC[v].cut_at != 0 && VEC[v].cut_at <= VEC[v].exp_on) begin
        check(on_cnt == VEC[v].exp_on, "R5 over-current on-time", on_cnt, VEC[v].exp_on);
        check(ocp_end, "R5 ocp_end pulse", ocp_end, 1);
      end else if (VEC[v].comp > CMAX)
        check(on_cnt == VEC[v].exp_on, "R3 clamped on-time", on_cnt, VEC[v].exp_on);
      else
        check(on_cnt == VEC[v].exp_on, "R2 ramp on-time", on_cnt, VEC[v].exp_on);
      ocp_flag = 1'b0;
    end

    // R6 blanking: edge right after a short on-time is dropped
    run_cycle(8'd20, 0, 0);
    drop_seen = 1'b0;
    zcd_cmp = 1'b1;
    repeat (2) @(negedge clk);
    zcd_cmp = 1'b0;
    watch_quiet(25, hits);
    check(hits == 0, "R6 early edge ignored", hits, 0);
    check(drop_seen, "R6 zcd_drop pulse", drop_seen, 1);
    run_cycle(8'd30, 0, 0);
    check(lat == LAT, "R6 later edge accepted", lat, LAT);
    check(on_cnt == 21, "R2 on-time after blanking", on_cnt, 21);

    // R7 restart timer
    run_cycle(8'd40, 0, 0);
    hits = 1;
    while (!gate && hits < 1000) begin
      @(negedge clk);
      if (!gate) hits++;
    end
    check(hits == RSTC, "R7 off cycles before forced turn-on", hits, RSTC);
    check(restart_fire, "R7 restart_fire pulse", restart_fire, 1);
    on_cnt = 0;
    while (gate && on_cnt < 1000) begin
      on_cnt++;
      @(negedge clk);
    end
    check(on_cnt == 41, "R7 forced cycle on-time", on_cnt, 41);
    comp_code = '0;

    // R4 COMP below floor
    run_cycle(8'd19, 0, 0);
    check(lat == 60 && on_cnt == 0, "R4 no turn-on below floor", on_cnt, 0);
    watch_quiet(450, hits);
    check(hits == 0, "R4 restart suppressed below floor", hits, 0);

    // R8 each inhibit bit cuts the on-time and blocks switching
    for (int b = 0; b < 4; b++) begin
      run_cycle(8'd130, 10, b + 1);
      check(on_cnt == 10, "R8 inhibit cuts on-time", on_cnt, 10);
      zcd_cmp = 1'b1;
      repeat (40) @(negedge clk);
      zcd_cmp = 1'b0;
      watch_quiet(450, hits);
      check(hits == 0, "R8 inhibit blocks edges and restart", hits, 0);
      inhibit = '0;
    end

    // R8 inhibit during turn-on delay clears the pending turn-on
    comp_code = 8'd50;
    zcd_cmp = 1'b1;
    repeat (40) @(negedge clk);
    zcd_cmp = 1'b0;
    repeat (3) @(negedge clk);
    inhibit[2] = 1'b1;
    @(negedge clk);
    inhibit = '0;
    watch_quiet(100, hits);
    check(hits == 0, "R8 pending turn-on cleared", hits, 0);
    comp_code = '0;
    repeat (5) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule